// File: doc/BRIEF.md
# Dual-Edge Interleaved Output Formatter

This block sits behind two 8-bit converter cores that sample one input on opposite edges of the sampling clock. In every sampling period the rising-edge core supplies the earlier sample and the falling-edge core the later one, so the two cores together form a single interleaved stream at twice the sampling rate. The block gathers that stream into parallel output words and forwards a data clock with each word.

In wide (1:2 demultiplexed) mode four output buses update together once every two sample pairs. In narrow mode two buses update once per pair. A static edge-select input chooses whether bus transitions line up with the rising or the falling edge of the forwarded data clock. A power-down input turns off the bus drivers and discards any partly gathered word. After power-down is released, a fixed number of words are marked invalid while the pipeline refills.

The block runs on a clock at least twice the sampling rate. It receives a sample pair, marked by `pairValid`, at most once every two block-clock cycles, and `demuxEn` changes only while power-down is high.

Top module: `ilv_out_formatter`

## Requirements
- R1: During reset and on the first clock edge after it, all four buses read 0, `wordValid` is 0, `outEnable` is 0 and `dclkOut` is 0.
- R2: With `demuxEn`=1, every two accepted pairs produce one word on the edge that accepts the second pair: `outDQd` = rise sample of the first pair, `outDId` = fall sample of the first pair, `outDQ` = rise sample of the second pair, `outDI` = fall sample of the second pair. The buses do not change on the edge that accepts the first pair.
- R3: With `demuxEn`=0, each accepted pair produces a word on the edge that accepts it: `outDQ` = rise sample, `outDI` = fall sample, and `outDQd` = `outDId` = 0.
- R4: On the edge that updates the buses, `dclkOut` takes the value `edgeSel` had at that edge, so the buses change together with a rising data-clock edge when `edgeSel`=1 and with a falling one when `edgeSel`=0. On every other edge `dclkOut` takes the inverse of `edgeSel`.
- R5: On each edge at which `pwrDown` is sampled high, `outEnable`, `wordValid` and all buses are set to 0. Pairs offered while `pwrDown` is high are dropped, and a half-gathered wide word is discarded.
- R6: The first FLUSH_WORDS (4) words produced after `pwrDown` falls still update the buses, but they leave `wordValid` at 0. The next word sets `wordValid` to 1.
- R7: `wordValid` and the bus values hold between words. After reset with no intervening power-down, the first word already sets `wordValid`.
- R8: On each edge with `pwrDown` sampled low, `outEnable` is set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least twice the sampling rate |
| rst_n | input | 1 | Active-low synchronous reset |
| demuxEn | input | 1 | 1 selects four-bus mode, 0 selects two-bus mode |
| edgeSel | input | 1 | 1: data changes on the rising data-clock edge; 0: on the falling edge |
| pwrDown | input | 1 | Power-down request |
| pairValid | input | 1 | A new rise/fall sample pair is present |
| riseSample | input | 8 | Sample from the rising-edge core (earlier of the pair) |
| fallSample | input | 8 | Sample from the falling-edge core (later of the pair) |
| outDQd | output | 8 | Wide mode: earliest sample of the group |
| outDId | output | 8 | Wide mode: second sample of the group |
| outDQ | output | 8 | Third sample (wide) or rise sample (narrow) |
| outDI | output | 8 | Latest sample of the group |
| dclkOut | output | 1 | Forwarded data clock |
| outEnable | output | 1 | Bus driver enable; 0 means the pads float |
| wordValid | output | 1 | Bus contents are meaningful |

## Verification
The bench feeds pairs with irregular gaps of one to three idle cycles. Each sample is a distinct count, so a swapped lane or a sample taken from the wrong pair shows up as a wrong value. Narrow mode is run with both edge-select settings, which tells the rising-edge data-clock alignment apart from the falling-edge one. Wide mode is entered through a power-down, so the flush count and the invalid words are exercised. A second power-down lands halfway through a wide group, which shows whether the half-gathered pair is thrown away or leaks into the next word.

// File: rtl/ilv_fmt_pkg.sv
package ilv_fmt_pkg;
  localparam int LANE_COUNT = 4;
  localparam int LANE_DQD = 0;
  localparam int LANE_DID = 1;
  localparam int LANE_DQ  = 2;
  localparam int LANE_DI  = 3;

  typedef struct packed {
    logic captureFirst;
    logic emitWord;
    logic demuxWord;
    logic clearAll;
  } fmt_strobe_t;
endpackage

// File: rtl/ilv_fmt_ctrl.sv
module ilv_fmt_ctrl
  import ilv_fmt_pkg::*;
#(
  parameter int FLUSH_WORDS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        demuxEn,
  input  logic        edgeSel,
  input  logic        pwrDown,
  input  logic        pairValid,
  output fmt_strobe_t strobes,
  output logic        dclkOut,
  output logic        wordValid,
  output logic        outEnable
);
  localparam int FLUSH_W = $clog2(FLUSH_WORDS + 1);
  localparam logic [FLUSH_W-1:0] FLUSH_LOAD = FLUSH_W'(FLUSH_WORDS);

  logic               halfHave;
  logic [FLUSH_W-1:0] flushLeft;
  logic               emitNow;
  logic               captureNow;

  always_comb begin
    emitNow    = !pwrDown && pairValid && (!demuxEn || halfHave);
    captureNow = !pwrDown && pairValid && demuxEn && !halfHave;
    strobes.captureFirst = captureNow;
    strobes.emitWord     = emitNow;
    strobes.demuxWord    = demuxEn;
    strobes.clearAll     = pwrDown;
  end

  // half-group tracker for the wide mode
  always_ff @(posedge clk) begin
    if (!rst_n) halfHave <= 1'b0;
    else if (pwrDown || !demuxEn) halfHave <= 1'b0;
    else if (pairValid) halfHave <= !halfHave;
  end

  // flush counter and valid flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flushLeft <= '0;
      wordValid <= 1'b0;
    end else if (pwrDown) begin
      flushLeft <= FLUSH_LOAD;
      wordValid <= 1'b0;
    end else if (emitNow) begin
      if (flushLeft != '0) begin
        flushLeft <= flushLeft - 1'b1;
        wordValid <= 1'b0;
      end else begin
        wordValid <= 1'b1;
      end
    end
  end

  // forwarded clock and driver enable
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dclkOut   <= 1'b0;
      outEnable <= 1'b0;
    end else begin
      dclkOut   <= emitNow ? edgeSel : !edgeSel;
      outEnable <= !pwrDown;
    end
  end

  AST_VALID_OFF_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
    pwrDown |=> (!wordValid && !outEnable)); // R5
  AST_NARROW_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !demuxEn |-> !strobes.captureFirst); // R3
  AST_FLUSH_KEEPS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (flushLeft != '0) |-> !wordValid); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.captureFirst, strobes.emitWord, strobes.clearAll})); // R2
endmodule

// File: rtl/ilv_fmt_datapath.sv
module ilv_fmt_datapath
  import ilv_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  fmt_strobe_t                          strobes,
  input  logic [SAMPLE_W-1:0]                  riseSample,
  input  logic [SAMPLE_W-1:0]                  fallSample,
  output logic [LANE_COUNT-1:0][SAMPLE_W-1:0]  laneOut
);
  logic [SAMPLE_W-1:0]                 holdRise;
  logic [SAMPLE_W-1:0]                 holdFall;
  logic [LANE_COUNT-1:0][SAMPLE_W-1:0] laneSrc;

  always_ff @(posedge clk) begin
    if (!rst_n || strobes.clearAll) begin
      holdRise <= '0;
      holdFall <= '0;
    end else if (strobes.captureFirst) begin
      holdRise <= riseSample;
      holdFall <= fallSample;
    end
  end

  always_comb begin
    laneSrc[LANE_DQ] = riseSample;
    laneSrc[LANE_DI] = fallSample;
    if (strobes.demuxWord) begin
      laneSrc[LANE_DQD] = holdRise;
      laneSrc[LANE_DID] = holdFall;
    end else begin
      laneSrc[LANE_DQD] = '0;
      laneSrc[LANE_DID] = '0;
    end
  end

  for (genvar g = 0; g < LANE_COUNT; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n || strobes.clearAll) laneOut[g] <= '0;
      else if (strobes.emitWord) laneOut[g] <= laneSrc[g];
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.captureFirst && !strobes.clearAll) |=> $stable(holdRise) && $stable(holdFall)); // R2
  AST_LANES_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clearAll |=> (laneOut == '0)); // R5
  AST_LANES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.emitWord && !strobes.clearAll) |=> $stable(laneOut)); // R7
endmodule

// File: rtl/ilv_out_formatter.sv
module ilv_out_formatter
  import ilv_fmt_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int FLUSH_WORDS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                demuxEn,
  input  logic                edgeSel,
  input  logic                pwrDown,
  input  logic                pairValid,
  input  logic [SAMPLE_W-1:0] riseSample,
  input  logic [SAMPLE_W-1:0] fallSample,
  output logic [SAMPLE_W-1:0] outDQd,
  output logic [SAMPLE_W-1:0] outDId,
  output logic [SAMPLE_W-1:0] outDQ,
  output logic [SAMPLE_W-1:0] outDI,
  output logic                dclkOut,
  output logic                outEnable,
  output logic                wordValid
);
  fmt_strobe_t                          strobes;
  logic [LANE_COUNT-1:0][SAMPLE_W-1:0]  laneOut;

  ilv_fmt_ctrl #(.FLUSH_WORDS(FLUSH_WORDS)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .demuxEn   (demuxEn),
    .edgeSel   (edgeSel),
    .pwrDown   (pwrDown),
    .pairValid (pairValid),
    .strobes   (strobes),
    .dclkOut   (dclkOut),
    .wordValid (wordValid),
    .outEnable (outEnable)
  );

  ilv_fmt_datapath #(.SAMPLE_W(SAMPLE_W)) data_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .riseSample (riseSample),
    .fallSample (fallSample),
    .laneOut    (laneOut)
  );

  assign outDQd = laneOut[LANE_DQD];
  assign outDId = laneOut[LANE_DID];
  assign outDQ  = laneOut[LANE_DQ];
  assign outDI  = laneOut[LANE_DI];

  AST_DATA_ON_CLOCK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(outDI) && !$past(pwrDown) && $past(rst_n)) |-> (dclkOut == $past(edgeSel))); // R4
  AST_ENABLE_FOLLOWS_PD: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrDown |=> outEnable); // R8
endmodule

// File: tb/ilv_out_formatter_tb.sv
module ilv_out_formatter_tb_top;
  localparam int SW = 8;
  localparam int FLUSH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          demuxEn = 1'b0;
  logic          edgeSel = 1'b1;
  logic          pwrDown = 1'b0;
  logic          pairValid = 1'b0;
  logic [SW-1:0] riseSample = '0;
  logic [SW-1:0] fallSample = '0;
  logic [SW-1:0] outDQd, outDId, outDQ, outDI;
  logic          dclkOut, outEnable, wordValid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ilv_out_formatter #(.SAMPLE_W(SW), .FLUSH_WORDS(FLUSH)) dut_i (
    .clk(clk), .rst_n(rst_n), .demuxEn(demuxEn), .edgeSel(edgeSel),
    .pwrDown(pwrDown), .pairValid(pairValid), .riseSample(riseSample),
    .fallSample(fallSample), .outDQd(outDQd), .outDId(outDId), .outDQ(outDQ),
    .outDI(outDI), .dclkOut(dclkOut), .outEnable(outEnable), .wordValid(wordValid)
  );

  // behavioural reference: a queue of interleaved samples
  int expQ[$];
  int expBus[4];
  int expDclk = 0, expOe = 0, expValid = 0, flushLeft = 0;
  bit wideWord = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      expQ.delete();
      foreach (expBus[i]) expBus[i] = 0;
      expDclk = 0; expOe = 0; expValid = 0; flushLeft = 0;
    end else if (pwrDown) begin
      expQ.delete();
      foreach (expBus[i]) expBus[i] = 0;
      expOe = 0; expValid = 0; flushLeft = FLUSH;
      expDclk = edgeSel ? 0 : 1;
    end else begin
      expOe = 1;
      expDclk = edgeSel ? 0 : 1;
      if (pairValid) begin
        expQ.push_back(int'(riseSample));
        expQ.push_back(int'(fallSample));
        if (expQ.size() == (demuxEn ? 4 : 2)) begin
          wideWord = demuxEn;
          if (demuxEn) begin
            for (int i = 0; i < 4; i++) expBus[i] = expQ[i];
          end else begin
            expBus[0] = 0; expBus[1] = 0; expBus[2] = expQ[0]; expBus[3] = expQ[1];
          end
          expQ.delete();
          expDclk = edgeSel ? 1 : 0;
          if (flushLeft == 0) expValid = 1;
          else begin expValid = 0; flushLeft--; end
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(wideWord ? "R2 outDQd" : "R3 outDQd", int'(outDQd), expBus[0]);
      chk(wideWord ? "R2 outDId" : "R3 outDId", int'(outDId), expBus[1]);
      chk(wideWord ? "R2 outDQ"  : "R3 outDQ",  int'(outDQ),  expBus[2]);
      chk(wideWord ? "R2 outDI"  : "R3 outDI",  int'(outDI),  expBus[3]);
      chk("R4 dclkOut", int'(dclkOut), expDclk);
      chk("R8 outEnable", int'(outEnable), expOe);
      chk("R6/R7 wordValid", int'(wordValid), expValid);
    end
  end

  int nextVal = 1;

  task automatic sendPairs(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pairValid  = 1'b1;
      riseSample = SW'(nextVal);
      fallSample = SW'(nextVal + 1);
      nextVal = (nextVal + 2) % 250;
      @(negedge clk);
      pairValid = 1'b0;
      for (int g = 0; g < (k % 3); g++) @(negedge clk);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state
    chk("R1 buses", int'({outDQd, outDId, outDQ, outDI} != 0), 0);
    chk("R1 wordValid", int'(wordValid), 0);
    chk("R1 outEnable", int'(outEnable), 0);
    chk("R1 dclkOut", int'(dclkOut), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first edge buses", int'(outDQ), 0);
    // R3, R4, R7: narrow mode, rising alignment, valid without flush
    sendPairs(6);
    chk("R7 valid after reset word", int'(wordValid), 1);
    edgeSel = 1'b0;
    sendPairs(5);
    idle(3);
    // R5: power-down, then switch to wide mode
    pwrDown = 1'b1;
    sendPairs(2);
    chk("R5 outEnable low", int'(outEnable), 0);
    chk("R5 buses zero", int'({outDQd, outDId, outDQ, outDI} != 0), 0);
    demuxEn = 1'b1;
    edgeSel = 1'b1;
    idle(2);
    pwrDown = 1'b0;
    // R6: flush four wide words, then valid
    sendPairs(8);
    chk("R6 valid after flush", int'(wordValid), 0);
    sendPairs(4);
    chk("R6 valid after fifth word", int'(wordValid), 1);
    edgeSel = 1'b0;
    sendPairs(3);
    // R5: power-down halfway through a wide group
    pwrDown = 1'b1;
    idle(3);
    pwrDown = 1'b0;
    sendPairs(12);
    demuxEn = 1'b1;
    idle(2);
    pwrDown = 1'b1;
    idle(2);
    demuxEn = 1'b0;
    pwrDown = 1'b0;
    sendPairs(7);
    idle(4);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule